// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire open-drain bus placed in front of a 4096 x 8 byte store. The clock and data lines arrive as raw inputs and pass through two-flop synchronisers inside the block. The block drives one output, a pull-down enable for the data line. It watches for start and stop conditions and answers only its own device address. After the address, it takes a 12-bit word address. It then accepts one byte to write, or it streams bytes back to the master.

A write does not reach the store when its data byte is acknowledged. The byte is held until the master ends the transfer with a stop. At that point the block writes the byte and enters a busy interval that stands in for a nonvolatile program cycle. The interval lasts `BUSY_CYCLES` system clocks. For that whole time the block ignores the bus, including its own address.

A read starts from the current address, which can first be set by a write header followed by a repeated start. The block sends bytes one after another for as long as the master acknowledges them. The address steps by one after each byte and wraps at the top of the store. The system clock must run at least eight times faster than the bus clock.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the pull-down enable is low. The block stays silent, with no acknowledge, for any bus clocks that come before a start condition (SDA falling while SCL is high).
- R2: The device byte is sent MSB first. Bits [7:4] must equal `DEV_TYPE` (default 4'b1010) and bits [3:1] must equal `devSel`, or the byte gets no acknowledge. Bit 0 selects the direction: 1 for read, 0 for write.
- R3: In a write, the block pulls SDA low during the ninth clock of the device byte, of both word-address bytes and of the first data byte.
- R4: The store changes only on a stop condition (SDA rising while SCL is high) that ends a write with an acknowledged data byte. A repeated start before the stop discards the pending byte and leaves the word address loaded.
- R5: After a committed write, the block gives no acknowledge to any byte for `BUSY_CYCLES` clocks. After that it answers its address again.
- R6: A read sends the byte at the current address MSB first. Each master acknowledge moves the address on by one, wrapping from 4095 to 0, and starts the next byte.
- R7: After a byte that the master does not acknowledge, the block releases SDA and drives nothing until the next start or stop.
- R8: The word address is two bytes. The low four bits of the first byte give address bits [11:8], and its upper four bits are ignored. The second byte gives bits [7:0].
- R9: A write takes one data byte. A second data byte in the same transfer gets no acknowledge, and the first byte is the one committed.
- R10: After a committed write to address A, a read with no new word address starts at (A+1) mod 4096.
- R11: The block changes its pull-down enable only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line, unsynchronised |
| sdaIn | input | 1 | Bus data line as seen on the wire, unsynchronised |
| devSel | input | 3 | Static device select value compared with device byte bits [3:1] |
| sdaOe | output | 1 | Pull-down enable for the data line (1 = drive low) |

## Verification
The bench changes SDA six system clocks after each SCL fall. It samples the wire at the middle of the SCL high phase. The block reacts three clocks after a line edge (two synchroniser flops plus the control register), so every acknowledge and data bit is settled well before the sample. A commit happens three clocks after the stop edge. The first address byte after it is judged about 220 clocks later, inside the 400-clock busy window the bench configures. The retry waits 500 clocks beyond that. Stored data is checked by reading it back through the bus, so every write result is compared one full transfer later against a bench-side copy of the store.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_AHI, PH_ALO, PH_DATA, PH_READ, PH_WAIT
  } phase_t;

  // decoded bus events from the synchronised lines
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sda;
  } busEv_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic setAddrHi;
    logic setAddrLo;
    logic holdData;
    logic commit;
    logic loadTx;
    logic shiftTx;
    logic incAddr;
  } dpCtrl_t;

endpackage

// File: rtl/smem_datapath.sv
module smem_datapath
  import smem_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BUSY_CYCLES = 1250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  dpCtrl_t    ctl,
  output busEv_t     ev,
  output logic [7:0] rxByte,
  output logic       txMsb,
  output logic       busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int BW    = $clog2(BUSY_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;

  // synchroniser chains built from the stage parameter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  assign ev.sclRise = sclS & ~sclP;
  assign ev.sclFall = ~sclS & sclP;
  assign ev.start   = sclS & sclP & sdaP & ~sdaS;
  assign ev.stop    = sclS & sclP & ~sdaP & sdaS;
  assign ev.sda     = sdaS;

  logic [ADDR_W-1:0] addr;
  logic [7:0]        dataReg, txReg, ramQ;
  logic [BW-1:0]     busyCnt;
  logic [7:0]        mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr    <= '0;
      dataReg <= '0;
      txReg   <= '0;
      rxByte  <= '0;
      busyCnt <= '0;
    end else begin
      if (ctl.shiftIn)   rxByte <= {rxByte[6:0], sdaS};
      if (ctl.setAddrHi) addr[ADDR_W-1:8] <= rxByte[HI_W-1:0];
      if (ctl.setAddrLo) addr[7:0] <= rxByte;
      if (ctl.holdData)  dataReg <= rxByte;
      if (ctl.commit || ctl.incAddr) addr <= addr + 1'b1;
      if (ctl.loadTx)       txReg <= ramQ;
      else if (ctl.shiftTx) txReg <= {txReg[6:0], 1'b0};
      if (ctl.commit)              busyCnt <= BW'(BUSY_CYCLES);
      else if (busyCnt != '0)      busyCnt <= busyCnt - 1'b1;
    end
  end

  // synchronous single-port store
  always_ff @(posedge clk) begin
    if (ctl.commit) mem[addr] <= dataReg;
    ramQ <= mem[addr];
  end

  assign txMsb = txReg[7];
  assign busy  = busyCnt != '0;
endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEv_t     ev,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  input  logic [2:0] devSel,
  input  logic       busy,
  output dpCtrl_t    ctl,
  output logic       sdaOe
);
  phase_t     phase;
  logic [3:0] bitCnt;
  logic       drvAck, drvTx, isRead, pendWr, mAck;
  logic       rxPhase, devMatch, ackOk;

  assign rxPhase  = phase inside {PH_DEV, PH_AHI, PH_ALO, PH_DATA};
  assign devMatch = (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == devSel);

  always_comb begin
    case (phase)
      PH_DEV:          ackOk = devMatch;
      PH_AHI, PH_ALO:  ackOk = 1'b1;
      PH_DATA:         ackOk = !pendWr;
      default:         ackOk = 1'b0;
    endcase
  end

  always_comb begin
    ctl = '0;
    if (!busy) begin
      if (ev.stop) begin
        ctl.commit = pendWr;
      end else if (!ev.start) begin
        if (ev.sclRise) begin
          ctl.shiftIn = rxPhase && bitCnt < 4'd8;
          ctl.incAddr = phase == PH_READ && bitCnt == 4'd8 && !ev.sda;
        end else if (ev.sclFall) begin
          if (rxPhase && bitCnt == 4'd8 && ackOk) begin
            ctl.setAddrHi = phase == PH_AHI;
            ctl.setAddrLo = phase == PH_ALO;
            ctl.holdData  = phase == PH_DATA;
          end
          if (phase == PH_DEV && bitCnt == 4'd9 && isRead) ctl.loadTx = 1'b1;
          if (phase == PH_READ) begin
            ctl.shiftTx = bitCnt inside {[4'd1:4'd7]};
            ctl.loadTx  = bitCnt == 4'd9 && mAck;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      drvAck <= 1'b0;
      drvTx  <= 1'b0;
      isRead <= 1'b0;
      pendWr <= 1'b0;
      mAck   <= 1'b0;
    end else if (busy || ev.stop || ev.start) begin
      phase  <= (!busy && ev.start) ? PH_DEV : PH_IDLE;
      bitCnt <= '0;
      drvAck <= 1'b0;
      drvTx  <= 1'b0;
      pendWr <= 1'b0;
    end else if (ev.sclRise) begin
      if (phase != PH_IDLE && phase != PH_WAIT) bitCnt <= bitCnt + 1'b1;
      if (phase == PH_READ && bitCnt == 4'd8) mAck <= !ev.sda;
    end else if (ev.sclFall) begin
      if (rxPhase) begin
        if (bitCnt == 4'd8) begin
          if (ackOk) begin
            drvAck <= 1'b1;
            if (phase == PH_DEV)  isRead <= rxByte[0];
            if (phase == PH_DATA) pendWr <= 1'b1;
          end else begin
            phase <= PH_WAIT;
          end
        end else if (bitCnt == 4'd9) begin
          drvAck <= 1'b0;
          bitCnt <= '0;
          case (phase)
            PH_DEV:  begin
              phase <= isRead ? PH_READ : PH_AHI;
              drvTx <= isRead;
            end
            PH_AHI:  phase <= PH_ALO;
            PH_ALO:  phase <= PH_DATA;
            default: phase <= PH_DATA;
          endcase
        end
      end else if (phase == PH_READ) begin
        if (bitCnt == 4'd8) drvTx <= 1'b0;
        if (bitCnt == 4'd9) begin
          bitCnt <= '0;
          if (mAck) drvTx <= 1'b1;
          else      phase <= PH_WAIT;
        end
      end
    end
  end

  assign sdaOe = drvAck | (drvTx & ~txMsb);
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import smem_pkg::*;
#(
  parameter int         ADDR_W      = 12,
  parameter int         BUSY_CYCLES = 1250000,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] devSel,
  output logic       sdaOe
);
  busEv_t     ev;
  dpCtrl_t    ctl;
  logic [7:0] rxByte;
  logic       txMsb, busy;

  smem_datapath #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .ev(ev), .rxByte(rxByte), .txMsb(txMsb), .busy(busy)
  );

  smem_ctrl #(.DEV_TYPE(DEV_TYPE)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .txMsb(txMsb),
    .devSel(devSel), .busy(busy), .ctl(ctl), .sdaOe(sdaOe)
  );
endmodule

// File: rtl/serial_mem_slave_chk.sv
module serial_mem_slave_chk
  import smem_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sclIn,
  input logic    sdaOe,
  input logic    busy,
  input logic    stopEv,
  input dpCtrl_t ctl
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !sdaOe);

  assert_commit_on_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> stopEv);

  assert_commit_starts_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> busy);

  assert_busy_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  assert_oe_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclIn);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.setAddrHi, ctl.setAddrLo, ctl.holdData, ctl.commit,
              ctl.loadTx, ctl.shiftTx, ctl.incAddr}));
endmodule

bind serial_mem_slave serial_mem_slave_chk chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .busy(busy), .stopEv(ev.stop), .ctl(ctl)
);

// File: tb/serial_mem_slave_test.sv
module serial_mem_slave_test;
  localparam int       Q      = 6;
  localparam int       BUSY_T = 400;
  localparam int       DEPTH  = 4096;
  localparam bit [2:0] SEL    = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaBus;

  always #2 clk = ~clk;

  assign sdaBus = sdaM & ~sdaOe;

  serial_mem_slave #(.ADDR_W(12), .BUSY_CYCLES(BUSY_T), .DEV_TYPE(4'b1010)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .devSel(SEL), .sdaOe(sdaOe)
  );

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;
  bit [7:0] refMem [DEPTH];
  bit       known  [DEPTH];
  int       refPtr = 0;

  function automatic bit [7:0] devWord(bit [3:0] typ, bit [2:0] s, bit rw);
    return {typ, s, rw};
  endfunction

  function automatic int nextAddr(int a);
    return (a + 1) % DEPTH;
  endfunction

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busBit(bit v, output bit got);
    sdaM = v;  tick(Q);
    sclM = 1;  tick(Q);
    got = sdaBus; tick(Q);
    sclM = 0;  tick(Q);
  endtask

  task automatic busStart();
    sdaM = 1; tick(Q);
    sclM = 1; tick(Q);
    sdaM = 0; tick(Q);
    sclM = 0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 0; tick(Q);
    sclM = 1; tick(Q);
    sdaM = 1; tick(Q);
  endtask

  task automatic sendByte(bit [7:0] b, output bit ack);
    bit g;
    for (int i = 7; i >= 0; i--) busBit(b[i], g);
    busBit(1'b1, g);
    ack = !g;
  endtask

  task automatic recvByte(bit ackIt, output bit [7:0] b);
    bit g;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      busBit(1'b1, g);
      b = {b[6:0], g};
    end
    busBit(!ackIt, g);
  endtask

  task automatic setAddr(int a, bit [7:0] hiPad, string req);
    bit ack;
    busStart();
    sendByte(devWord(4'b1010, SEL, 1'b0), ack); chk({req, " dev ack"}, ack, 1);
    sendByte(hiPad | 8'(a >> 8), ack);          chk({req, " hi ack"}, ack, 1);
    sendByte(8'(a), ack);                       chk({req, " lo ack"}, ack, 1);
    refPtr = a;
  endtask

  task automatic writeByte(int a, bit [7:0] d, bit waitBusy);
    bit ack;
    setAddr(a, 8'h00, "R3");
    sendByte(d, ack); chk("R3 data ack", ack, 1);
    busStop();
    refMem[a] = d;
    known[a]  = 1'b1;
    refPtr    = nextAddr(a);
    if (waitBusy) tick(BUSY_T + 100);
  endtask

  // read n bytes from the current address, acking all but the last
  task automatic readRun(int n, string req);
    bit ack;
    bit [7:0] b;
    busStart();
    sendByte(devWord(4'b1010, SEL, 1'b1), ack); chk({req, " read dev ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      if (known[refPtr]) chk(req, b, refMem[refPtr]);
      refPtr = nextAddr(refPtr);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog expired, run hung");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    bit ack, g;
    bit [7:0] b;
    void'($urandom(32'd2718));
    tick(5);
    chk("R1 oe in reset", sdaOe, 0);
    rstN = 1'b1;
    tick(5);
    chk("R1 oe after reset", sdaOe, 0);

    // R1: a matching byte without a start must not be answered
    sclM = 0; tick(Q);
    sendByte(devWord(4'b1010, SEL, 1'b0), ack);
    chk("R1 no ack before start", ack, 0);
    busStop();

    // R2: address compare
    busStart();
    sendByte(devWord(4'b0101, SEL, 1'b0), ack); chk("R2 wrong type nack", ack, 0);
    busStop();
    busStart();
    sendByte(devWord(4'b1010, ~SEL, 1'b0), ack); chk("R2 wrong select nack", ack, 0);
    busStop();
    busStart();
    sendByte(devWord(4'b1010, SEL, 1'b1), ack); chk("R2 match ack", ack, 1);
    recvByte(1'b0, b);
    busStop();

    // R5: busy window after a commit
    writeByte(0, 8'h3C, 1'b1);
    writeByte(4095, 8'h5A, 1'b0);
    busStart();
    sendByte(devWord(4'b1010, SEL, 1'b0), ack); chk("R5 nack while busy", ack, 0);
    busStop();
    tick(BUSY_T + 100);
    // R10 + R6 wrap: current address after writing 4095 is 0
    readRun(1, "R10 next after write");
    busStop();

    // R6: sequential read across the wrap, R7: release after nack
    setAddr(4095, 8'h00, "R6");
    readRun(3, "R6 wrap stream");
    busBit(1'b1, g); chk("R7 released bit", g, 1);
    chk("R7 oe low", sdaOe, 0);
    busBit(1'b1, g); chk("R7 released bit 2", g, 1);
    busStop();

    // R4: repeated start drops a pending write
    writeByte(100, 8'h11, 1'b1);
    setAddr(100, 8'h00, "R4");
    sendByte(8'h99, ack); chk("R4 data ack", ack, 1);
    readRun(1, "R4 no commit on restart");
    busStop();

    // R8: upper nibble of the first address byte ignored
    setAddr(12'h123, 8'hE0, "R8");
    sendByte(8'hA7, ack); chk("R8 data ack", ack, 1);
    busStop();
    refMem[12'h123] = 8'hA7; known[12'h123] = 1'b1;
    tick(BUSY_T + 100);
    setAddr(12'h123, 8'h00, "R8");
    readRun(1, "R8 stored at low 12 bits");
    busStop();

    // R9: only one data byte per write
    setAddr(200, 8'h00, "R9");
    sendByte(8'h42, ack); chk("R9 first data ack", ack, 1);
    sendByte(8'h24, ack); chk("R9 second data nack", ack, 0);
    busStop();
    refMem[200] = 8'h42; known[200] = 1'b1;
    tick(BUSY_T + 100);
    setAddr(200, 8'h00, "R9");
    readRun(1, "R9 first byte kept");
    busStop();

    // random writes with read back
    for (int it = 0; it < 18; it++) begin
      int a;
      a = int'($urandom % DEPTH);
      writeByte(a, 8'($urandom), 1'b1);
      setAddr(a, 8'h00, "R6");
      readRun(1 + int'($urandom % 3), "R6 random read");
      busStop();
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule